// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects an internal requester to an external asynchronous static RAM of 2048 bytes. A request has a write/read flag, an 11-bit word address and, for writes, one data byte. The controller turns each request into a fixed sequence of chip-select, output-enable and write-enable levels on the memory side. Every strobe is a register output, so the memory sees clean edges.

Each phase lasts a whole number of clock cycles. The count is computed at elaboration from the clock period in nanoseconds and the memory's minimum timings, rounded up. Writes are ended by write enable, with chip select held low around the pulse. The data bus is split into an outgoing byte, an incoming byte and a drive-enable, so the surrounding pad logic can build the tristate buffer.

After a read, the controller holds off driving the bus long enough for the memory's output drivers to release it. The hold-off applies only when a write follows. A read that follows a read starts at once.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and in every cycle in which the controller is idle, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, and `busy` and `done` are 0. Reset takes effect without waiting for a clock edge.
- R2: A request is taken at a rising clock edge where `req_valid` is 1 and `busy` is 0. `req_write` = 1 selects a write and 0 selects a read. `busy` is 1 from the cycle after that edge until the cycle in which `done` is 1. A request raised while `busy` is 1 has no effect.
- R3: A read drives `mem_cs_n` and `mem_oe_n` low together, with `mem_we_n` high and `mem_addr` equal to the request address, for exactly N_RD cycles. N_RD is the largest of the read-cycle, address-access and output-enable-access times, each divided by the clock period and rounded up. With the default parameters N_RD is 5.
- R4: `rsp_rdata` takes the value of `mem_dq_in` sampled at the clock edge that ends the last read-access cycle, and holds it until the next read. `done` is 1 for exactly one cycle, the cycle that follows that edge. With the default parameters this is N_RD+1 = 6 cycles after the accepting edge.
- R5: A write has three phases. First, one setup cycle with `mem_cs_n` low and `mem_we_n` high. Second, exactly N_WP cycles with `mem_we_n` low; at the defaults N_WP = 4, which meets the 20 ns pulse, the 15 ns data setup and the 25 ns write cycle at 5 ns per clock. Third, one hold cycle with `mem_we_n` high and `mem_cs_n` still low. `done` is 1 in the cycle after the hold cycle, N_WP+3 = 7 cycles after the accepting edge when no hold-off is pending.
- R6: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is low and in the one cycle after `mem_we_n` returns high. Throughout, `mem_dq_out` carries the request data. `mem_oe_n` stays 1 for the whole write. The byte stored by the memory equals the request data.
- R7: After a read, `mem_dq_oe` rises no sooner than N_TURN cycles after `mem_oe_n` rises. N_TURN is the larger of the output-enable and chip-select release times, each divided by the clock period and rounded up; at the defaults it is 3. A write taken in the cycle right after a read's `done` therefore completes at cycle 8 instead of cycle 7. A read is never delayed by this hold-off.
- R8: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0, so the controller and the memory never drive the data bus at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, asserted asynchronously and released synchronously |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Data captured by the last read |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 11 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus pads |
| mem_dq_in | input | 8 | Byte sensed on the data bus |

## Verification
The bench counts falling clock edges from the edge that accepted a request.

Timing of each result:
- A read's `done` and `rsp_rdata` are due at count 6.
- A write's `done` is due at count 7, or at count 8 when the write directly follows a read.
- Over the same window the bench counts 5 cycles of output enable low for a read, 4 cycles of write enable low for a write, and 5 cycles of data drive for a write.
- The bus hold-off after a read is counted from the rise of output enable to the rise of the drive enable, and must equal 3 cycles.

The memory model in the bench presents valid read data only from the fifth access cycle onward, so a capture made one edge early returns corrupted data. The model stores data only if the drive enable is still high in the cycle after write enable rises. All outputs are sampled on falling edges, half a period away from the edges that update them.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;

  // Whole clock cycles needed to cover t_ns, rounded up.
  function automatic int cycles_for(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/asram_turn_guard.sv
module asram_turn_guard #(
  parameter int N_TURN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic drive_ok
);

  generate
    if (N_TURN == 0) begin : g_no_gap
      assign drive_ok = 1'b1;
    end else begin : g_gap
      localparam int TW = $clog2(N_TURN + 1);
      logic [TW-1:0] gap_q, gap_d;

      always_comb begin
        gap_d = gap_q;
        if (load)              gap_d = TW'(N_TURN);
        else if (gap_q != '0)  gap_d = gap_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
      end

      // The setup cycle itself absorbs the last count.
      assign drive_ok = (gap_q <= TW'(1));
    end
  endgenerate

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= din;
  end

  assign dout = data_q;

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int N_RD   = 5,
  parameter int N_WP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              turn_ok,
  output logic              busy,
  output logic              done,
  output logic              cap_en,
  output logic              turn_load,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int CNT_W = $clog2(imax(N_RD, N_WP) + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(N_WP - 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cs_q, cs_d, oe_q, oe_d, we_q, we_d, dq_q, dq_d;
  logic              done_q, done_d;
  logic              take_req;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign take_req = (st_q == ST_IDLE) && req_valid;

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cs_d      = cs_q;
    oe_d      = oe_q;
    we_d      = we_q;
    dq_d      = dq_q;
    done_d    = 1'b0;
    cap_en    = 1'b0;
    turn_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cs_d = 1'b0;
          if (req_write) begin
            st_d = ST_WR_SETUP;
          end else begin
            oe_d  = 1'b0;
            cnt_d = RD_LOAD;
            st_d  = ST_RD_ACC;
          end
        end
      end
      ST_RD_ACC: begin
        if (cnt_q == '0) begin
          cap_en    = 1'b1;
          turn_load = 1'b1;
          cs_d      = 1'b1;
          oe_d      = 1'b1;
          done_d    = 1'b1;
          st_d      = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_SETUP: begin
        if (turn_ok) begin
          we_d  = 1'b0;
          dq_d  = 1'b1;
          cnt_d = WP_LOAD;
          st_d  = ST_WR_PULSE;
        end
      end
      ST_WR_PULSE: begin
        if (cnt_q == '0) begin
          we_d = 1'b1;
          st_d = ST_WR_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_HOLD: begin
        dq_d   = 1'b0;
        cs_d   = 1'b1;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State and strobe registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cs_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      dq_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cs_q   <= cs_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      dq_q   <= dq_d;
      done_q <= done_d;
    end
  end

  // Request holding registers, loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign mem_addr   = addr_q;
  assign mem_cs_n   = cs_q;
  assign mem_oe_n   = oe_q;
  assign mem_we_n   = we_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 25,
  parameter int T_AA_NS  = 25,
  parameter int T_OE_NS  = 15,
  parameter int T_WC_NS  = 25,
  parameter int T_WP_NS  = 20,
  parameter int T_AW_NS  = 20,
  parameter int T_DS_NS  = 15,
  parameter int T_OHZ_NS = 10,
  parameter int T_CHZ_NS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_RD = imax(imax(cycles_for(T_AA_NS, CLK_NS), cycles_for(T_OE_NS, CLK_NS)),
                             imax(cycles_for(T_RC_NS, CLK_NS), 1));
  // One setup cycle precedes the pulse and one hold cycle follows it.
  localparam int N_WP = imax(imax(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_DS_NS, CLK_NS)),
                             imax(cycles_for(T_AW_NS, CLK_NS) - 1,
                                  imax(cycles_for(T_WC_NS, CLK_NS) - 2, 1)));
  localparam int N_TURN = imax(cycles_for(T_OHZ_NS, CLK_NS), cycles_for(T_CHZ_NS, CLK_NS));

  logic core_rst_n;
  logic turn_ok, turn_load, cap_en;

  asram_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  asram_turn_guard #(.N_TURN(N_TURN)) u_turn (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (turn_load),
    .drive_ok (turn_ok)
  );

  asram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_RD   (N_RD),
    .N_WP   (N_WP)
  ) u_seq (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .turn_ok    (turn_ok),
    .busy       (busy),
    .done       (done),
    .cap_en     (cap_en),
    .turn_load  (turn_load),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .cap_en (cap_en),
    .din    (mem_dq_in),
    .dout   (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int N_RD   = 5,
  parameter int N_WP   = 4,
  parameter int N_TURN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mem_cs_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);

  logic        prev_oe_n, prev_we_n, prev_dq_oe;
  logic [15:0] rd_len, we_len, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_oe_n  <= 1'b1;
      prev_we_n  <= 1'b1;
      prev_dq_oe <= 1'b0;
      rd_len     <= '0;
      we_len     <= '0;
      since_oe   <= 16'(N_TURN);
    end else begin
      prev_oe_n  <= mem_oe_n;
      prev_we_n  <= mem_we_n;
      prev_dq_oe <= mem_dq_oe;
      rd_len     <= mem_oe_n ? '0 : rd_len + 1'b1;
      we_len     <= mem_we_n ? '0 : we_len + 1'b1;
      if (!mem_oe_n)                   since_oe <= '0;
      else if (since_oe < 16'(N_TURN)) since_oe <= since_oe + 1'b1;
    end
  end

  a_r1_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_read_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_oe_n && mem_oe_n) |-> (rd_len == 16'(N_RD)));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_we_n && mem_we_n) |-> (we_len == 16'(N_WP) && !mem_cs_n));

  a_r6_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dq_oe));

  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_we_n && mem_we_n) |-> mem_dq_oe);

  a_r6_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && mem_we_n) |=> !mem_dq_oe);

  a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_dq_oe && mem_dq_oe) |-> (since_oe >= 16'(N_TURN)));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .N_RD   (N_RD),
  .N_WP   (N_WP),
  .N_TURN (N_TURN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int N_RD   = 5;
  localparam int N_WP   = 4;
  localparam int N_TURN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        busy, done;
  logic [10:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .busy       (busy),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  // Memory model: data valid only from the N_RD-th access cycle on
  logic [7:0] arr [0:2047];
  int  acc = 0;
  logic prev_we = 1'b1;

  function automatic logic [7:0] init_val(input logic [10:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) arr[i] = init_val(11'(i));
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n) acc <= (acc < 100) ? acc + 1 : acc;
    else                                    acc <= 0;
    prev_we <= mem_we_n;
    if (!mem_cs_n && mem_we_n && !prev_we)
      arr[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hEE;
  end

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n)
                   ? ((acc >= N_RD - 1) ? arr[mem_addr] : ~arr[mem_addr]) : 8'h00;

  // Bus monitors, sampled on falling edges
  int contention = 0;
  int oe_hi_run = 100;
  int last_gap = -1;
  logic prev_dq = 1'b0;

  always @(negedge clk) begin
    if (mem_dq_oe && !mem_oe_n) contention++;
    if (mem_dq_oe && !prev_dq) last_gap = oe_hi_run;
    oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
    prev_dq = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issue one request from a falling edge, return counts up to done
  task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d,
                       output int lat, output int oe_lo, output int we_lo,
                       output int dq_hi, output logic [7:0] rd);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; oe_lo = 0; we_lo = 0; dq_hi = 0;
    while (lat < 50) begin
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) we_lo++;
      if (mem_dq_oe) dq_hi++;
      if (done) break;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  task automatic t_reset_state();
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes inactive in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe && !busy && !done, "R1 drive/busy/done low in reset", {mem_dq_oe, busy, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
  endtask

  task automatic t_write(input logic [10:0] a, input logic [7:0] d);
    int lat, oe_lo, we_lo, dq_hi; logic [7:0] rd;
    issue(1'b1, a, d, lat, oe_lo, we_lo, dq_hi, rd);
    chk(lat == N_WP + 3, "R5 write done latency", lat, N_WP + 3);
    chk(we_lo == N_WP, "R5 write enable low cycles", we_lo, N_WP);
    chk(dq_hi == N_WP + 1 && oe_lo == 0, "R6 drive window and oe high", dq_hi, N_WP + 1);
    chk(arr[a] == d, "R6 memory holds write data", arr[a], d);
  endtask

  task automatic t_read(input logic [10:0] a, input logic [7:0] exp);
    int lat, oe_lo, we_lo, dq_hi; logic [7:0] rd;
    issue(1'b0, a, 8'h00, lat, oe_lo, we_lo, dq_hi, rd);
    chk(lat == N_RD + 1, "R4 read done latency (R7 no delay)", lat, N_RD + 1);
    chk(oe_lo == N_RD && we_lo == 0, "R3 read strobe cycles", oe_lo, N_RD);
    chk(rd == exp, "R4 read data", rd, exp);
    @(negedge clk);
    chk(!done && !busy, "R4 done is one cycle", {done, busy}, 0);
  endtask

  task automatic t_read_then_write();
    int lat, oe_lo, we_lo, dq_hi; logic [7:0] rd;
    issue(1'b0, 11'h555, 8'h00, lat, oe_lo, we_lo, dq_hi, rd);
    chk(rd == init_val(11'h555), "R4 read before turnaround", rd, init_val(11'h555));
    issue(1'b1, 11'h555, 8'hA5, lat, oe_lo, we_lo, dq_hi, rd);
    chk(lat == N_WP + 4, "R7 write after read latency", lat, N_WP + 4);
    chk(last_gap == N_TURN, "R7 oe rise to drive gap", last_gap, N_TURN);
    chk(we_lo == N_WP, "R5 pulse after turnaround", we_lo, N_WP);
    @(negedge clk);
    t_read(11'h555, 8'hA5);
  endtask

  task automatic t_busy_ignore();
    int dones = 0; bit busy_seen;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h100; req_wdata = 8'h11;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    busy_seen = busy;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h101; req_wdata = 8'h22;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy_seen, "R2 busy during access", busy_seen, 1);
    for (int i = 0; i < 20; i++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R2 single completion", dones, 1);
    chk(arr[11'h100] == 8'h11, "R2 accepted write stored", arr[11'h100], 8'h11);
    t_read(11'h101, init_val(11'h101));
  endtask

  task automatic t_reset_mid();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h7AB;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_cs_n && mem_oe_n && !busy, "R1 reset aborts access at once",
        {mem_cs_n, mem_oe_n, busy}, 3'b110);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !busy && mem_cs_n, "R1 idle after mid reset", {done, busy, mem_cs_n}, 1);
    t_read(11'h7AB, init_val(11'h7AB));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_write(11'h000, 8'h5A);
    t_write(11'h7FF, 8'hFF);
    t_write(11'h2AA, 8'h00);
    t_read(11'h7FF, 8'hFF);
    t_read(11'h000, 8'h5A);
    t_read(11'h2AA, 8'h00);
    t_read_then_write();
    t_busy_ignore();
    t_reset_mid();
    chk(contention == 0, "R8 no bus contention", contention, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule